// File: doc/BRIEF.md
# ATA Task File Register Block

This block is the device-side register file of a parallel ATA disk port. A host reaches it through eight register offsets selected by a 3-bit address, with separate read and write strobes. Several offsets change meaning with direction: offset 1 takes a feature byte on write and returns the error byte on read. Offset 7 takes a command opcode on write and returns the status byte on read. The block holds the sector count, the three LBA bytes and the device/head byte. It drives a level interrupt line that stays asserted until the host reads status.

A small command engine sits behind the registers. IDENTIFY DEVICE (0xEC) opens a PIO-in phase in which 256 reads of the 16-bit data port stream words from a computed identification ROM. FLUSH CACHE (0xE7) holds the device busy until a one-cycle `flush_done` pulse arrives from the cache logic outside the block. Any other opcode, or any command addressed to device 1, is rejected with an abort. Read data is combinational on the address. Side effects of a read (clearing the interrupt, advancing the data word) take place on the clock edge while `bus_rd` is high.

Top module: `ata_regfile`

## Requirements
- R1: After reset, status reads 0x40 (ready only), error reads 0x00, `irq` is low, and offsets 2 to 6 read 0x00.
- R2: In the idle state, a byte written to offset 2, 3, 4, 5 or 6 reads back unchanged from the same offset, in the low byte with the upper byte zero. A write to offset 1 leaves the error byte read at offset 1 unchanged.
- R3: Status bit encodings are busy 0x80, ready 0x40, device fault 0x20, data request 0x08 and error 0x01. Busy and data request are never set together, and device fault is never set.
- R4: Writing 0xEC to offset 7 on device 0 gives status 0x48 and raises `irq`. Exactly 256 data-port reads follow, each with status 0x48. After the 256th read, status returns to 0x40.
- R5: During IDENTIFY, the k-th data-port read (k from 0) returns the 16-bit word {k[7:0] XOR 0x5A, NOT k[7:0]}.
- R6: Writing 0xE7 to offset 7 on device 0 gives status 0xC0 until a `flush_done` pulse. In the cycle after that pulse, status is 0x40 and `irq` is high. A `flush_done` pulse while no flush is pending has no effect on status or `irq`.
- R7: An opcode other than 0xEC or 0xE7, or any command written while device byte bit 0x10 is set, gives status 0x41, error 0x04 (abort) and raises `irq`.
- R8: A read strobe at offset 7 clears `irq` on that edge. A read strobe at offset 1 leaves `irq` unchanged.
- R9: While status shows busy or data request, writes to offsets 1 to 7 are ignored: register contents, status and the IDENTIFY word position are unchanged.
- R10: An accepted command clears a previous abort: error reads 0x00 and status bit 0x01 is clear.
- R11: A data-port read outside the IDENTIFY phase returns 0x0000 and changes neither status nor `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; side effects take place on the edge |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request, level |
| flush_done | input | 1 | One-cycle completion pulse for a pending flush |

## Verification
The bench builds the block with its default 256-word identification length, so the whole word stream and the wrap back to idle at the final word are covered directly. Using the default length also means the computed ROM contents are checked at every index, including the top one. The 8-bit register width lets random bytes reach every bit of each task file register. Random delays before `flush_done` bring busy-phase writes and stray completion pulses within reach.

// File: rtl/ata_tf_pkg.sv
`timescale 1ns/1ps
package ata_tf_pkg;
    localparam int ADDR_W = 3;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    localparam logic [ADDR_W-1:0] OFS_DATA  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_FTERR = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_SECT  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_LBA0  = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_LBA1  = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_LBA2  = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_DEV   = 3'd6;
    localparam logic [ADDR_W-1:0] OFS_CMDST = 3'd7;

    localparam int ST_BSY_B  = 7;
    localparam int ST_RDY_B  = 6;
    localparam int ST_FLT_B  = 5;
    localparam int ST_DRQ_B  = 3;
    localparam int ST_ERR_B  = 0;

    localparam logic [BYTE_W-1:0] ERRB_ABORT = 8'h04;
    localparam int DEV_SEL_B = 4;

    localparam logic [BYTE_W-1:0] OPC_IDENT = 8'hEC;
    localparam logic [BYTE_W-1:0] OPC_FLUSH = 8'hE7;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_PIOIN = 2'd1,
        ENG_FLUSH = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic              rd;
        logic [BYTE_W-1:0] wdata;
    } host_req_t;

    typedef struct packed {
        logic [BYTE_W-1:0] sect;
        logic [BYTE_W-1:0] lba0;
        logic [BYTE_W-1:0] lba1;
        logic [BYTE_W-1:0] lba2;
        logic [BYTE_W-1:0] dev;
    } taskfile_t;

    function automatic logic [WORD_W-1:0] id_word(input int unsigned k);
        logic [7:0] b;
        b = 8'(k);
        return {b ^ 8'h5A, ~b};
    endfunction
endpackage

// File: rtl/ata_id_rom.sv
`timescale 1ns/1ps
module ata_id_rom
    import ata_tf_pkg::*;
#(
    parameter int WORDS = 256,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] word
);
    always_comb word = id_word(32'(idx));
endmodule

// File: rtl/ata_taskfile_regs.sv
`timescale 1ns/1ps
module ata_taskfile_regs
    import ata_tf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  host_req_t         req,
    input  logic              lock,
    output taskfile_t         tf,
    output logic              cmd_stb,
    output logic [BYTE_W-1:0] cmd_code
);
    logic wr_ok;
    assign wr_ok    = req.wr && !lock;
    assign cmd_stb  = wr_ok && (req.addr == OFS_CMDST);
    assign cmd_code = req.wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            tf <= '0;
        end else if (wr_ok) begin
            case (req.addr)
                OFS_SECT: tf.sect <= req.wdata;
                OFS_LBA0: tf.lba0 <= req.wdata;
                OFS_LBA1: tf.lba1 <= req.wdata;
                OFS_LBA2: tf.lba2 <= req.wdata;
                OFS_DEV:  tf.dev  <= req.wdata;
                default:  ;
            endcase
        end
    end

    // R9: a locked write leaves every task file byte as it was
    p_locked_write_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (lock && req.wr) |=> $stable(tf));

    // R2: an unlocked write to a holding offset lands in that register
    p_sect_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && req.addr == OFS_SECT) |=> (tf.sect == $past(req.wdata)));
endmodule

// File: rtl/ata_cmd_engine.sv
`timescale 1ns/1ps
module ata_cmd_engine
    import ata_tf_pkg::*;
#(
    parameter int WORDS = 256,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_stb,
    input  logic [BYTE_W-1:0] cmd_code,
    input  logic              dev_sel1,
    input  logic              data_rd,
    input  logic              stat_rd,
    input  logic              flush_done,
    output logic [BYTE_W-1:0] status,
    output logic [BYTE_W-1:0] error,
    output logic              irq,
    output logic              lock,
    output logic              in_xfer,
    output logic [IDX_W-1:0]  word_idx
);
    eng_state_e state, state_n;
    logic [IDX_W-1:0] idx_n;
    logic abort, abort_n, irq_set;

    always_comb begin
        state_n = state;
        idx_n   = word_idx;
        abort_n = abort;
        irq_set = 1'b0;
        case (state)
            ENG_IDLE: if (cmd_stb) begin
                irq_set = 1'b1;
                if (dev_sel1 || (cmd_code != OPC_IDENT && cmd_code != OPC_FLUSH)) begin
                    abort_n = 1'b1;
                end else begin
                    abort_n = 1'b0;
                    if (cmd_code == OPC_IDENT) begin
                        state_n = ENG_PIOIN;
                        idx_n   = '0;
                    end else begin
                        state_n = ENG_FLUSH;
                        irq_set = 1'b0;
                    end
                end
            end
            ENG_PIOIN: if (data_rd) begin
                if (word_idx == LAST_IDX) begin
                    state_n = ENG_IDLE;
                    idx_n   = '0;
                end else begin
                    idx_n = word_idx + 1'b1;
                end
            end
            ENG_FLUSH: if (flush_done) begin
                state_n = ENG_IDLE;
                irq_set = 1'b1;
            end
            default: state_n = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ENG_IDLE;
            word_idx <= '0;
            abort    <= 1'b0;
            irq      <= 1'b0;
        end else begin
            state    <= state_n;
            word_idx <= idx_n;
            abort    <= abort_n;
            if (irq_set)      irq <= 1'b1;
            else if (stat_rd) irq <= 1'b0;
        end
    end

    always_comb begin
        status           = '0;
        status[ST_RDY_B] = 1'b1;
        status[ST_BSY_B] = (state == ENG_FLUSH);
        status[ST_DRQ_B] = (state == ENG_PIOIN);
        status[ST_ERR_B] = abort;
        error            = abort ? ERRB_ABORT : '0;
    end

    assign lock    = (state != ENG_IDLE);
    assign in_xfer = (state == ENG_PIOIN);

    // R3: busy and data request exclusive, no fault
    p_bsy_drq_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(status[ST_BSY_B] && status[ST_DRQ_B]) && !status[ST_FLT_B]);

    // R8: a status read with no simultaneous event drops the interrupt
    p_stat_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !(state == ENG_IDLE && cmd_stb)
                 && !(state == ENG_FLUSH && flush_done)) |=> !irq);

    // R6: flush holds busy until its completion pulse
    p_flush_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ENG_FLUSH && !flush_done) |=> status[ST_BSY_B]);

    // R6: completion pulse ends the flush with interrupt
    p_flush_done_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ENG_FLUSH && flush_done) |=> (!status[ST_BSY_B] && irq));

    // R7: command to device 1 aborts
    p_dev1_abort_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ENG_IDLE && cmd_stb && dev_sel1) |=>
            (error == ERRB_ABORT && status[ST_ERR_B] && irq));

    // R4: word position stays inside the identification block
    p_idx_range_r4: assert property (@(posedge clk) disable iff (rst)
        (32'(word_idx) < WORDS));
endmodule

// File: rtl/ata_regfile.sv
`timescale 1ns/1ps
module ata_regfile
    import ata_tf_pkg::*;
#(
    parameter int ID_WORDS = 256,
    localparam int IDX_W = (ID_WORDS > 1) ? $clog2(ID_WORDS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    output logic                irq,
    input  logic                flush_done
);
    host_req_t         req;
    taskfile_t         tf;
    logic              lock, in_xfer, cmd_stb;
    logic [BYTE_W-1:0] cmd_code, status, error;
    logic [IDX_W-1:0]  word_idx;
    logic [WORD_W-1:0] rom_word;

    assign req = '{addr: bus_addr, wr: bus_wr, rd: bus_rd, wdata: bus_wdata};

    ata_taskfile_regs u_regs (
        .clk(clk), .rst(rst), .req(req), .lock(lock),
        .tf(tf), .cmd_stb(cmd_stb), .cmd_code(cmd_code)
    );

    ata_cmd_engine #(.WORDS(ID_WORDS)) u_eng (
        .clk(clk), .rst(rst),
        .cmd_stb(cmd_stb), .cmd_code(cmd_code),
        .dev_sel1(tf.dev[DEV_SEL_B]),
        .data_rd(req.rd && req.addr == OFS_DATA),
        .stat_rd(req.rd && req.addr == OFS_CMDST),
        .flush_done(flush_done),
        .status(status), .error(error), .irq(irq),
        .lock(lock), .in_xfer(in_xfer), .word_idx(word_idx)
    );

    ata_id_rom #(.WORDS(ID_WORDS)) u_rom (
        .idx(word_idx), .word(rom_word)
    );

    always_comb begin
        case (bus_addr)
            OFS_DATA:  bus_rdata = in_xfer ? rom_word : '0;
            OFS_FTERR: bus_rdata = {8'h00, error};
            OFS_SECT:  bus_rdata = {8'h00, tf.sect};
            OFS_LBA0:  bus_rdata = {8'h00, tf.lba0};
            OFS_LBA1:  bus_rdata = {8'h00, tf.lba1};
            OFS_LBA2:  bus_rdata = {8'h00, tf.lba2};
            OFS_DEV:   bus_rdata = {8'h00, tf.dev};
            default:   bus_rdata = {8'h00, status};
        endcase
    end

    // R11: the data port is silent outside the identification phase
    p_data_idle_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (!in_xfer && bus_addr == OFS_DATA) |-> (bus_rdata == '0));
endmodule

// File: tb/ata_regfile_tb.sv
`timescale 1ns/1ps
module ata_regfile_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;
    logic        flush_done = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [7:0] model [2:6];

    always #10 clk = ~clk;

    ata_regfile u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .flush_done(flush_done)
    );

    function automatic logic [15:0] exp_word(input int k);
        logic [7:0] b;
        b = 8'(k);
        return {b ^ 8'h5A, ~b};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        flush_done = 1'b1;
        @(negedge clk);
        flush_done = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        logic [15:0] d;
        logic [7:0]  op;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        peek(3'd7, d); chk("R1 status", d, 16'h0040);
        peek(3'd1, d); chk("R1 error", d, 16'h0000);
        chk("R1 irq", 16'(irq), 16'h0);
        for (int a = 2; a <= 6; a++) begin
            peek(3'(a), d); chk("R1 regs", d, 16'h0000);
            model[a] = 8'h00;
        end

        // R2 random register writes and readback
        for (int i = 0; i < 40; i++) begin
            int a;
            logic [7:0] v;
            a = 2 + int'($urandom_range(4));
            v = 8'($urandom);
            if (a == 6) v[4] = 1'b0;
            bwrite(3'(a), v);
            model[a] = v;
            for (int b = 2; b <= 6; b++) begin
                peek(3'(b), d); chk("R2 readback", d, {8'h00, model[b]});
            end
        end
        bwrite(3'd1, 8'($urandom));
        peek(3'd1, d); chk("R2 feature write", d, 16'h0000);

        // R7 invalid opcodes, R8 interrupt clear rules
        for (int i = 0; i < 6; i++) begin
            do op = 8'($urandom); while (op == 8'hEC || op == 8'hE7);
            bwrite(3'd7, op);
            @(negedge clk);
            peek(3'd7, d); chk("R7 status", d, 16'h0041);
            peek(3'd1, d); chk("R7 error", d, 16'h0004);
            chk("R7 irq", 16'(irq), 16'h1);
            bread(3'd1, d);
            chk("R8 error read keeps irq", 16'(irq), 16'h1);
            bread(3'd7, d);
            chk("R8 status read clears irq", 16'(irq), 16'h0);
        end

        // R7 device 1
        bwrite(3'd6, 8'h50); model[6] = 8'h50;
        bwrite(3'd7, 8'hEC);
        peek(3'd7, d); chk("R7 dev1 status", d, 16'h0041);
        chk("R7 dev1 irq", 16'(irq), 16'h1);
        bread(3'd7, d);
        bwrite(3'd6, 8'h40); model[6] = 8'h40;

        // R11 idle data read
        bread(3'd0, d); chk("R11 idle data", d, 16'h0000);
        peek(3'd7, d); chk("R11 status kept", d, 16'h0041);
        chk("R11 irq kept", 16'(irq), 16'h0);

        // R4 R5 R10 identify
        for (int rep = 0; rep < 2; rep++) begin
            bwrite(3'd7, 8'hEC);
            peek(3'd7, d); chk("R4 drq status", d, 16'h0048);
            chk("R4 irq", 16'(irq), 16'h1);
            peek(3'd1, d); chk("R10 error cleared", d, 16'h0000);
            bread(3'd7, d);
            chk("R8 clear in pio", 16'(irq), 16'h0);
            bwrite(3'd2, 8'hA5);
            peek(3'd2, d); chk("R9 locked sect", d, {8'h00, model[2]});
            bwrite(3'd7, 8'hE7);
            for (int k = 0; k < 256; k++) begin
                peek(3'd7, d); chk("R4 per word status", d, 16'h0048);
                bread(3'd0, d); chk("R5 word", d, exp_word(k));
            end
            peek(3'd7, d); chk("R4 end status", d, 16'h0040);
            peek(3'd6, d); chk("R4 device bit 0", d & 16'h0010, 16'h0000);
        end

        // R6 stray done pulse
        pulse_done();
        peek(3'd7, d); chk("R6 stray done status", d, 16'h0040);
        chk("R6 stray done irq", 16'(irq), 16'h0);

        // R6 R9 flush with random delays
        for (int rep = 0; rep < 8; rep++) begin
            int dly;
            dly = 1 + int'($urandom_range(15));
            bwrite(3'd7, 8'hE7);
            for (int c = 0; c < dly; c++) begin
                @(negedge clk);
                peek(3'd7, d); chk("R6 busy", d, 16'h00C0);
            end
            bwrite(3'd3, 8'($urandom));
            peek(3'd3, d); chk("R9 locked lba", d, {8'h00, model[3]});
            bwrite(3'd7, 8'hEC);
            peek(3'd7, d); chk("R9 locked cmd", d, 16'h00C0);
            pulse_done();
            peek(3'd7, d); chk("R6 done status", d, 16'h0040);
            chk("R6 done irq", 16'(irq), 16'h1);
            bread(3'd7, d);
            chk("R8 clear after flush", 16'(irq), 16'h0);
            if (rep % 2 == 1) begin
                bwrite(3'd7, 8'h00);
                peek(3'd7, d); chk("R7 abort between", d, 16'h0041);
                bread(3'd7, d);
            end
        end

        done = 1'b1;
        finish_run();
    end
endmodule